// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation converter that talks to a host over a three-wire serial link. The link has an active-low select, a serial clock, a data input and a data output. When select goes low, the block watches the data input on rising clock edges. It waits for a start bit of one, then shifts in a short channel and mode selection word and hands it to the analog multiplexer. It allows one clock for acquisition and then runs a binary search of eight steps. Each step presents a trial code to an external DAC and reads back a single comparator decision.

Each decision appears on the data output at the falling clock edge that follows its resolution, so the host first receives the result most-significant bit first. The finished code is then copied into a shift register and sent a second time, least-significant bit first. After that the output is held low until select rises again. While select is high the output is released, the low-power flag is raised and all sequencing state is held in its idle value. The data input is read only during the start and address phase, and the output driver stays off for all of that phase, so the host may tie both data lines to a single wire.

The trial code is split into a 5-bit field for a capacitor array and a 3-bit field for a resistor ladder.

Top module: `sar_ser_ctrl`

## Requirements
- R1: While `cs_n` is high, `do_oe` is low, `lowpwr` is high and `sel_vld` is low. Clock edges and `di` activity during that time leave the block idle, so no transaction starts until `cs_n` is low and a start bit is seen.
- R2: With `cs_n` low, `di` is sampled on rising `sclk` edges. Zeros are ignored until the first one, which is the start bit.
- R3: The ADDR_W bits after the start bit, sent MSB first, form `sel`. `sel_vld` rises after the last of them. Later `di` values do not change `sel` for the rest of the transaction.
- R4: `do_oe` stays low through the idle, start, address and acquisition clocks and through the first trial step.
- R5: The search takes RES steps from the MSB down. In the step for bit b, the trial code is the kept upper bits with bit b set and all lower bits zero. `cmp` is sampled on the rising edge that ends the step, and a one keeps bit b. With a comparator that reports input >= trial, the final code equals the input value.
- R6: `dac_hi` carries trial bits [7:3] and `dac_lo` carries trial bits [2:0]. Both are zero outside the search.
- R7: Each decision is driven on `dout`, with `do_oe` high, from the falling edge after the rising edge that resolved it. The last decision is resolved on the 13th rising edge, counting the start-bit edge as the first (default ADDR_W = 3).
- R8: After the last decision, the full result is sent again LSB first, one bit per falling edge, bit 0 first. Bit 0 therefore appears in two consecutive periods.
- R9: After bit RES-1 of the second pass, `dout` is driven low until `cs_n` rises. `done` pulses high for exactly one clock, with `result` equal to the final code.
- R10: Raising `cs_n` in the middle of a transaction drops `do_oe` at once, without waiting for a clock. The next transaction runs from a clean idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select; high aborts and idles |
| di | input | 1 | Serial data in (start and address) |
| cmp | input | 1 | Comparator decision, 1 = input at or above trial |
| dout | output | 1 | Serial data out, high-Z when `do_oe` low |
| do_oe | output | 1 | Output driver enable |
| lowpwr | output | 1 | Low-power indication |
| sel | output | ADDR_W | Captured multiplexer selection |
| sel_vld | output | 1 | Selection captured for this transaction |
| dac_hi | output | HI_W | Upper trial field (capacitor array) |
| dac_lo | output | RES-HI_W | Lower trial field (resistor ladder) |
| done | output | 1 | One-clock pulse at end of second pass |
| result | output | RES | Final conversion code |

## Verification
The bench runs all 256 input codes, each with a different selection word and 0 to 2 idle zeros before the start bit. A design that counts the start bit as address, or that starts on a zero, captures the wrong `sel` or shifts every later bit by one period. The bench counts periods exactly, so a decision driven one edge early or late, a trial code that fails to clear or keep a bit, or a second pass that skips the repeated bit 0 or reverses the order gives a bit mismatch. Separate runs raise select in the middle of the search and toggle the clock and data while idle. A design that keeps state across an abort, or that starts while deselected, gives a wrong code or an early `sel_vld`.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACQ,
    ST_CONV,
    ST_SHIFT,
    ST_DONE
  } seq_state_e;

  // Counter must hold RES (second pass index) and ADDR_W-1.
  function automatic int unsigned seq_cnt_width(input int unsigned res,
                                                input int unsigned aw);
    int unsigned top_val;
    top_val = (res > aw) ? res : aw;
    return $clog2(top_val + 1);
  endfunction

endpackage

// File: rtl/sar_addr.sv
module sar_addr #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              di,
  output logic [ADDR_W-1:0] sel
);

  logic [ADDR_W-1:0] sel_q;

  generate
    if (ADDR_W == 1) begin : g_single
      always_ff @(posedge clk or posedge clr) begin
        if (clr)           sel_q <= '0;
        else if (shift_en) sel_q <= di;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge clr) begin
        if (clr)           sel_q <= '0;
        else if (shift_en) sel_q <= {sel_q[ADDR_W-2:0], di};
      end
    end
  endgenerate

  assign sel = sel_q;

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ser_pkg::*;
#(
  parameter int RES    = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             di,
  output logic [CNT_W-1:0] cnt,
  output logic             addr_shift,
  output logic             conv_en,
  output logic             conv_last,
  output logic             shift_en,
  output logic             in_shift,
  output logic             sel_vld,
  output logic             oe_nxt,
  output logic             done
);

  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CONV_FIRST = CNT_W'(RES - 1);
  localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(RES);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;
  logic             pass_end;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (di) begin
          state_d = ST_ADDR;
          cnt_d   = ADDR_LAST;
        end
      end
      ST_ADDR: begin
        if (cnt_q == '0) state_d = ST_ACQ;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_ACQ: begin
        state_d = ST_CONV;
        cnt_d   = CONV_FIRST;
      end
      ST_CONV: begin
        if (cnt_q == '0) state_d = ST_SHIFT;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_SHIFT: begin
        if (cnt_q == SHIFT_LAST) state_d = ST_DONE;
        else                     cnt_d   = cnt_q + 1'b1;
      end
      ST_DONE: ;
      default: state_d = ST_IDLE;
    endcase
  end

  assign pass_end = (state_q == ST_SHIFT) && (cnt_q == SHIFT_LAST);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= pass_end;
    end
  end

  assign cnt        = cnt_q;
  assign addr_shift = (state_q == ST_ADDR);
  assign conv_en    = (state_q == ST_CONV);
  assign conv_last  = conv_en && (cnt_q == '0);
  assign in_shift   = (state_q == ST_SHIFT);
  assign shift_en   = in_shift && (cnt_q != '0);
  assign sel_vld    = (state_q == ST_ACQ) || (state_q == ST_CONV) ||
                      (state_q == ST_SHIFT) || (state_q == ST_DONE);
  assign oe_nxt     = (conv_en && (cnt_q != CONV_FIRST)) || in_shift ||
                      (state_q == ST_DONE);
  assign done       = done_q;

endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES   = 8,
  parameter int HI_W  = 5,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               conv_en,
  input  logic               conv_last,
  input  logic               shift_en,
  input  logic [CNT_W-1:0]   bit_idx,
  input  logic               cmp,
  output logic [RES-1:0]     trial,
  output logic [HI_W-1:0]    dac_hi,
  output logic [RES-HI_W-1:0] dac_lo,
  output logic [RES-1:0]     result,
  output logic               dec_bit,
  output logic               ser_bit
);

  localparam int LO_W = RES - HI_W;

  logic [RES-1:0] sar_q;
  logic [RES-1:0] sh_q;
  logic [RES-1:0] sar_next;
  logic [RES-1:0] dec_vec;
  int             idx;

  // Replace one bit of a code word.
  function automatic logic [RES-1:0] put_bit(input logic [RES-1:0] v,
                                             input int pos,
                                             input logic b);
    logic [RES-1:0] r;
    r      = v;
    r[pos] = b;
    return r;
  endfunction

  assign idx      = int'(bit_idx);
  assign sar_next = put_bit(sar_q, idx, cmp);
  assign trial    = conv_en ? put_bit(sar_q, idx, 1'b1) : '0;
  assign dac_hi   = trial[RES-1 -: HI_W];
  assign dac_lo   = trial[LO_W-1:0];

  // Decision resolved on the previous edge sits one position above idx.
  assign dec_vec  = sar_q >> (idx + 1);
  assign dec_bit  = dec_vec[0];

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      sar_q <= '0;
      sh_q  <= '0;
    end else begin
      if (conv_en) sar_q <= sar_next;
      if (conv_last)     sh_q <= sar_next;
      else if (shift_en) sh_q <= sh_q >> 1;
    end
  end

  assign result  = sar_q;
  assign ser_bit = sh_q[0];

endmodule

// File: rtl/sar_dout.sv
module sar_dout (
  input  logic clk,
  input  logic clr,
  input  logic cs_n,
  input  logic oe_nxt,
  input  logic bit_nxt,
  output logic dout,
  output logic do_oe
);

  logic oe_q;
  logic bit_q;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      oe_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      oe_q  <= oe_nxt;
      bit_q <= bit_nxt;
    end
  end

  assign do_oe = oe_q & ~cs_n;
  assign dout  = do_oe ? bit_q : 1'bz;

endmodule

// File: rtl/sar_ser_ctrl.sv
module sar_ser_ctrl #(
  parameter int RES    = 8,
  parameter int HI_W   = 5,
  parameter int ADDR_W = 3
) (
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                di,
  input  logic                cmp,
  output logic                dout,
  output logic                do_oe,
  output logic                lowpwr,
  output logic [ADDR_W-1:0]   sel,
  output logic                sel_vld,
  output logic [HI_W-1:0]     dac_hi,
  output logic [RES-HI_W-1:0] dac_lo,
  output logic                done,
  output logic [RES-1:0]      result
);

  localparam int CNT_W = sar_ser_pkg::seq_cnt_width(RES, ADDR_W);

  logic             clr;
  logic [CNT_W-1:0] bit_idx;
  logic             addr_shift;
  logic             conv_en;
  logic             conv_last;
  logic             shift_en;
  logic             in_shift;
  logic             oe_nxt;
  logic             bit_nxt;
  logic             dec_bit;
  logic             ser_bit;
  logic [RES-1:0]   trial;

  assign clr    = cs_n | ~rst_n;
  assign lowpwr = cs_n;

  sar_seq #(.RES(RES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(sclk), .clr(clr), .di(di), .cnt(bit_idx),
    .addr_shift(addr_shift), .conv_en(conv_en), .conv_last(conv_last),
    .shift_en(shift_en), .in_shift(in_shift), .sel_vld(sel_vld),
    .oe_nxt(oe_nxt), .done(done)
  );

  sar_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(sclk), .clr(clr), .shift_en(addr_shift), .di(di), .sel(sel)
  );

  sar_reg #(.RES(RES), .HI_W(HI_W), .CNT_W(CNT_W)) u_reg (
    .clk(sclk), .clr(clr), .conv_en(conv_en), .conv_last(conv_last),
    .shift_en(shift_en), .bit_idx(bit_idx), .cmp(cmp), .trial(trial),
    .dac_hi(dac_hi), .dac_lo(dac_lo), .result(result),
    .dec_bit(dec_bit), .ser_bit(ser_bit)
  );

  assign bit_nxt = conv_en ? dec_bit : (in_shift ? ser_bit : 1'b0);

  sar_dout u_dout (
    .clk(sclk), .clr(clr), .cs_n(cs_n), .oe_nxt(oe_nxt),
    .bit_nxt(bit_nxt), .dout(dout), .do_oe(do_oe)
  );

endmodule

// File: rtl/sar_ser_ctrl_chk.sv
module sar_ser_ctrl_chk #(
  parameter int RES   = 8,
  parameter int CNT_W = 4
) (
  input logic             sclk,
  input logic             rst_n,
  input logic             clr,
  input logic             cs_n,
  input logic             do_oe,
  input logic             lowpwr,
  input logic             sel_vld,
  input logic             conv_en,
  input logic [CNT_W-1:0] bit_idx,
  input logic [RES-1:0]   trial,
  input logic             done,
  input logic [RES-1:0]   result
);

  assert_idle_R1: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> (lowpwr && !do_oe && !sel_vld));

  assert_quiet_addr_R4: assert property (@(posedge sclk) disable iff (clr)
    !sel_vld |-> !do_oe);

  assert_first_trial_R5: assert property (@(posedge sclk) disable iff (clr)
    (conv_en && bit_idx == CNT_W'(RES - 1)) |-> trial == (RES'(1) << (RES - 1)));

  assert_trial_step_R5: assert property (@(posedge sclk) disable iff (clr)
    (conv_en && $past(conv_en)) |-> ((trial & ~$past(trial)) == (RES'(1) << bit_idx)));

  assert_oe_hold_R8: assert property (@(posedge sclk) disable iff (clr)
    $past(do_oe) |-> do_oe);

  assert_done_pulse_R9: assert property (@(posedge sclk) disable iff (clr)
    done |=> !done);

  assert_result_stable_R9: assert property (@(posedge sclk) disable iff (clr)
    done |-> $stable(result));

endmodule

bind sar_ser_ctrl sar_ser_ctrl_chk #(.RES(RES), .CNT_W(CNT_W)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .do_oe(do_oe),
  .lowpwr(lowpwr), .sel_vld(sel_vld), .conv_en(conv_en), .bit_idx(bit_idx),
  .trial(trial), .done(done), .result(result)
);

// File: tb/sar_ser_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ser_ctrl_tb;

  localparam int RES    = 8;
  localparam int HI_W   = 5;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n, cs_n, di, cmp;
  logic              dout, do_oe, lowpwr, sel_vld, done;
  logic [ADDR_W-1:0] sel;
  logic [HI_W-1:0]   dac_hi;
  logic [RES-HI_W-1:0] dac_lo;
  logic [RES-1:0]    result;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  sar_ser_ctrl #(.RES(RES), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_dut (
    .rst_n(rst_n), .sclk(clk), .cs_n(cs_n), .di(di), .cmp(cmp),
    .dout(dout), .do_oe(do_oe), .lowpwr(lowpwr), .sel(sel),
    .sel_vld(sel_vld), .dac_hi(dac_hi), .dac_lo(dac_lo),
    .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // One rising edge, then settle just after the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic convert(input logic [7:0] vin, input logic [2:0] addr,
                         input int lead, input int abort_bit);
    logic [7:0] kept;
    logic [7:0] trial_e;
    logic       dec;
    cs_n = 1'b0; di = 1'b0; cmp = 1'b0;
    #1;
    chk(!lowpwr, "R1 lowpwr drops", int'(lowpwr), 0);
    for (int i = 0; i < lead; i++) begin
      tick();
      chk(!do_oe && !sel_vld, "R2 zero before start ignored", int'(sel_vld), 0);
    end
    di = 1'b1;                       // start bit: edge 1
    tick();
    chk(!do_oe, "R4 off after start", int'(do_oe), 0);
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      chk(!sel_vld, "R3 sel_vld early", int'(sel_vld), 0);
      di = addr[i];                  // edges 2..4
      tick();
      chk(!do_oe, "R4 off in address", int'(do_oe), 0);
    end
    chk(sel_vld && sel == addr, "R3 captured sel", int'(sel), int'(addr));
    di = ~addr[0];                   // acquisition: edge 5
    tick();
    chk(!do_oe, "R4 off in first trial", int'(do_oe), 0);
    kept = '0;
    for (int b = 7; b >= 0; b--) begin
      trial_e = kept | (8'h01 << b);
      chk({dac_hi, dac_lo} == trial_e, "R5 trial code", int'({dac_hi, dac_lo}), int'(trial_e));
      chk(dac_hi == trial_e[7:3] && dac_lo == trial_e[2:0], "R6 field split",
          int'(dac_hi), int'(trial_e[7:3]));
      dec = (vin >= trial_e);
      cmp = dec;
      di  = b[0];
      tick();                        // edges 6..13
      if (dec) kept[b] = 1'b1;
      if (abort_bit == b) begin
        cs_n = 1'b1;
        #1;
        chk(!do_oe && lowpwr, "R10 abort releases", int'(do_oe), 0);
        tick();
        return;
      end
      chk(do_oe && dout == dec, "R7 MSB-first decision", int'(dout), int'(dec));
    end
    chk(kept == vin, "R5 search lands on input", int'(kept), int'(vin));
    for (int k = 0; k < RES; k++) begin
      tick();
      chk(do_oe && dout == vin[k], "R8 LSB-first bit", int'(dout), int'(vin[k]));
    end
    tick();
    chk(done && result == vin, "R9 done with result", int'(result), int'(vin));
    chk(do_oe && dout == 1'b0, "R9 low after pass", int'(dout), 0);
    chk(sel == addr, "R3 sel held", int'(sel), int'(addr));
    tick();
    chk(!done && do_oe && dout == 1'b0, "R9 single pulse, still low", int'(done), 0);
    cs_n = 1'b1;
    #1;
    chk(!do_oe && lowpwr, "R1 released on deselect", int'(do_oe), 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; di = 1'b0; cmp = 1'b0;
    repeat (3) tick();
    chk(!do_oe && lowpwr && !done && !sel_vld, "R1 reset state", int'(do_oe), 0);
    rst_n = 1'b1;
    tick();

    // R1: activity while deselected must not start a transaction.
    di = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(!do_oe && lowpwr && !sel_vld, "R1 frozen while deselected", int'(sel_vld), 0);
    end
    cs_n = 1'b0; di = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(!sel_vld && !do_oe, "R1 no start carried over", int'(sel_vld), 0);
    end
    cs_n = 1'b1;
    tick();

    // Full sweep of input codes with varied selection and start delay.
    for (int v = 0; v < 256; v++) begin
      convert(8'(v), 3'(v) ^ 3'(v >> 3), v % 3, -1);
    end

    // R10: aborts at several points, each followed by a clean conversion.
    convert(8'hA5, 3'd5, 0, 3);
    convert(8'h5A, 3'd2, 1, -1);
    convert(8'hFF, 3'd7, 0, 7);
    convert(8'h01, 3'd1, 0, -1);
    convert(8'h80, 3'd4, 2, 0);
    convert(8'h7F, 3'd6, 0, -1);

    report();
  end

endmodule